// File: doc/BRIEF.md
# Six-Source Interrupt Enable and Polling Unit

This block is the interrupt front end of a small 8-bit controller. It keeps a flag for each event coming from two external inputs, three timers and a serial port. It masks the flags with an enable register and splits the pending sources into two priority levels. Once per machine cycle, on the last clock of that cycle, it polls the result. If a source may be served, it raises a request to the CPU together with a 3-bit vector index.

The CPU pulses a take strobe when it vectors to the request. That strobe marks the request's level as in service and clears the flag for those sources whose flag hardware owns. A return pulse clears the highest level in service. The first two timers set their flags late in a machine cycle, so the poll sees those flags one machine cycle later than the flags of the third timer, the external inputs and the serial port.

Top module: `irq_poll_unit`

## Requirements
- R1: After reset, the enable readback, priority readback, flag state, in-service state and request are all zero.
- R2: Enable write bits 5..0 enable sources in the order ext0, tmr0, ext1, tmr1, serial, tmr2, and bit 7 is a global enable. A source can raise a request only when both its own bit and the global bit are 1.
- R3: Enable bit 6 is not implemented. It always reads 0, and a write of 1 to it is ignored (a write of 8'hFF reads back 8'hBF).
- R4: Source tmr2 is pending when either flag index 5 (overflow) or flag index 6 (external) is set. Taking its vector clears neither flag; only the software clear input does.
- R5: A tmr0 (flag 1) or tmr1 (flag 3) set pulse in any clock of machine cycle k is first seen by the poll at the end of cycle k+1.
- R6: An ext0 (flag 0), ext1 (flag 2), serial (flag 4) or tmr2 flag set in a clock before the last clock of cycle k is seen by the poll of cycle k.
- R7: A machine cycle is CYC_LEN clocks, with the poll on its last clock. The request is updated only at a poll, except that a take drops it in the next clock.
- R8: A high-priority pending source (priority bit 1) wins over every low one. Within a level, the lowest vector index wins; the vector index equals the source number of R2.
- R9: A high request may pre-empt a low service. Nothing is requested while the high level is in service, and low requests wait until no level is in service.
- R10: A take (irqTake while irqReq is 1) sets in-service bit 1 (high) or bit 0 (low) for the request's level. It clears flags 0..3 of the taken source, and leaves the serial flag (4) set.
- R11: A retAck pulse clears in-service bit 1 if it is set, and otherwise clears bit 0.
- R12: When a set pulse and a clear (software or take) hit the same flag in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ieWe | input | 1 | Enable register write strobe |
| ieWdata | input | 8 | Enable write data |
| ieRdata | output | 8 | Enable register readback |
| prioWe | input | 1 | Priority register write strobe |
| prioWdata | input | 6 | Priority per source, 1 = high |
| prioRdata | output | 6 | Priority readback |
| setIn | input | 7 | Flag set pulses, index order ext0, tmr0, ext1, tmr1, serial, tmr2 overflow, tmr2 external |
| swClr | input | 7 | Software flag clear pulses, same index order |
| flagState | output | 7 | Current flags |
| irqTake | input | 1 | CPU takes the current request |
| retAck | input | 1 | CPU return from service |
| irqReq | output | 1 | Interrupt request |
| irqVec | output | 3 | Vector index of the request |
| inSvc | output | 2 | In-service levels, bit 1 high, bit 0 low |

## Verification
The hardest situation to reach is nested service. A low service has to be taken, a low source has to be shown to be held off, and then a high source has to pre-empt it and be unwound by two returns, all while the poll phase rolls on. The directed part of the stimulus aligns each set pulse to the start of a machine cycle by counting phases from reset, so that the one-cycle lag of the first two timers shows up at a known poll. A long random section then mixes takes and returns with set and clear pulses that land on arbitrary phases, including the poll clock itself. A behavioural model is compared against the outputs on every clock throughout.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  localparam int NSRC  = 6;
  localparam int NFLAG = 7;
  localparam int VEC_W = 3;
  localparam int NLATE = 2;

  typedef struct packed {
    logic             pollEdge;
    logic             clrValid;
    logic [VEC_W-1:0] clrSrc;
  } ctlStrobe_t;

  function automatic logic [VEC_W-1:0] firstSet(input logic [NSRC-1:0] v);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) idx = VEC_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/irq_poll_dp.sv
module irq_poll_dp
  import irq_poll_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ieWe,
  input  logic [7:0]       ieWdata,
  input  logic             prioWe,
  input  logic [NSRC-1:0]  prioWdata,
  input  logic [NFLAG-1:0] setIn,
  input  logic [NFLAG-1:0] swClr,
  input  ctlStrobe_t       strobe,
  output logic [7:0]       ieRdata,
  output logic [NSRC-1:0]  prioRdata,
  output logic [NFLAG-1:0] flagState,
  output logic [NSRC-1:0]  pendHi,
  output logic [NSRC-1:0]  pendLo
);
  logic [NSRC-1:0]  ieEn;
  logic             ieGlobal;
  logic [NSRC-1:0]  prioR;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] flagsNext;
  logic [NFLAG-1:0] hwClr;
  logic [NLATE-1:0] lateSeen;
  logic [NLATE-1:0] lateNext;
  logic [NLATE-1:0] lateFlag;
  logic [NSRC-1:0]  view;
  logic [NSRC-1:0]  pending;

  // Taking a vector clears the flags of ext0, tmr0, ext1 and tmr1 (index == source).
  always_comb begin
    hwClr = '0;
    if (strobe.clrValid && strobe.clrSrc < VEC_W'(4)) hwClr[strobe.clrSrc] = 1'b1;
  end

  assign flagsNext = (flags & ~swClr & ~hwClr) | setIn;
  assign lateFlag  = {flagsNext[3], flagsNext[1]};
  // A late flag becomes visible to the poll only once a poll edge has passed with it set.
  assign lateNext  = (strobe.pollEdge ? {NLATE{1'b1}} : lateSeen) & lateFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieEn     <= '0;
      ieGlobal <= 1'b0;
      prioR    <= '0;
      flags    <= '0;
      lateSeen <= '0;
    end else begin
      flags    <= flagsNext;
      lateSeen <= lateNext;
      if (ieWe) begin
        ieEn     <= ieWdata[NSRC-1:0];
        ieGlobal <= ieWdata[7];
      end
      if (prioWe) prioR <= prioWdata;
    end
  end

  assign view[0] = flags[0];
  assign view[1] = flags[1] & lateSeen[0];
  assign view[2] = flags[2];
  assign view[3] = flags[3] & lateSeen[1];
  assign view[4] = flags[4];
  assign view[5] = flags[5] | flags[6];

  assign pending   = ieGlobal ? (view & ieEn) : '0;
  assign pendHi    = pending & prioR;
  assign pendLo    = pending & ~prioR;
  assign ieRdata   = {ieGlobal, 1'b0, ieEn};
  assign prioRdata = prioR;
  assign flagState = flags;

  // R10: a taken external or tmr0/tmr1 vector leaves its flag clear unless re-set
  assert_take_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|(hwClr & ~setIn)) |=> ((flags & $past(hwClr & ~setIn)) == '0));

  // R4: taking a vector never clears the tmr2 flags
  assert_tmr2_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrValid && swClr[6:5] == 2'b00) |=>
      ((flags[6:5] & $past(flags[6:5])) == $past(flags[6:5])));
endmodule

// File: rtl/irq_poll_ctl.sv
module irq_poll_ctl
  import irq_poll_pkg::*;
#(
  parameter int CYC_LEN = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  pendHi,
  input  logic [NSRC-1:0]  pendLo,
  input  logic             irqTake,
  input  logic             retAck,
  output ctlStrobe_t       strobe,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVec,
  output logic [1:0]       inSvc
);
  localparam int PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);

  logic [PH_W-1:0]  phase;
  logic             pollEdge;
  logic             take;
  logic             hiOk;
  logic             loOk;
  logic             reqR;
  logic             lvlR;
  logic [VEC_W-1:0] vecR;
  logic [1:0]       svcR;
  logic [1:0]       svcNext;

  assign pollEdge = (phase == LAST_PH);
  assign take     = irqTake & reqR;
  assign hiOk     = (|pendHi) && !svcR[1];
  assign loOk     = (|pendLo) && (svcR == 2'b00);

  always_comb begin
    svcNext = svcR;
    if (retAck) begin
      if (svcR[1]) svcNext[1] = 1'b0;
      else         svcNext[0] = 1'b0;
    end
    if (take) svcNext[lvlR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      reqR  <= 1'b0;
      lvlR  <= 1'b0;
      vecR  <= '0;
      svcR  <= '0;
    end else begin
      phase <= pollEdge ? '0 : phase + 1'b1;
      svcR  <= svcNext;
      if (take) begin
        reqR <= 1'b0;
      end else if (pollEdge) begin
        reqR <= hiOk | loOk;
        lvlR <= hiOk;
        vecR <= hiOk ? firstSet(pendHi) : firstSet(pendLo);
      end
    end
  end

  assign strobe.pollEdge = pollEdge;
  assign strobe.clrValid = take;
  assign strobe.clrSrc   = vecR;
  assign irqReq          = reqR;
  assign irqVec          = vecR;
  assign inSvc           = svcR;

  // R7: a request only appears right after a poll clock
  assert_req_on_poll_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(pollEdge));

  // R9: no request is outstanding while the high level is in service
  assert_no_req_under_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && inSvc[1]));

  // R2: a poll with nothing pending leaves no request
  assert_idle_poll_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pollEdge && !take && pendHi == '0 && pendLo == '0) |=> !irqReq);

  // R10: a take marks its level in service
  assert_take_marks_R10: assert property (@(posedge clk) disable iff (!rstN)
    take |=> ($past(lvlR) ? inSvc[1] : inSvc[0]));
endmodule

// File: rtl/irq_poll_unit.sv
module irq_poll_unit
  import irq_poll_pkg::*;
#(
  parameter int CYC_LEN = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ieWe,
  input  logic [7:0]  ieWdata,
  output logic [7:0]  ieRdata,
  input  logic        prioWe,
  input  logic [5:0]  prioWdata,
  output logic [5:0]  prioRdata,
  input  logic [6:0]  setIn,
  input  logic [6:0]  swClr,
  output logic [6:0]  flagState,
  input  logic        irqTake,
  input  logic        retAck,
  output logic        irqReq,
  output logic [2:0]  irqVec,
  output logic [1:0]  inSvc
);
  ctlStrobe_t      strobe;
  logic [NSRC-1:0] pendHi;
  logic [NSRC-1:0] pendLo;

  irq_poll_dp u_dp (
    .clk(clk), .rstN(rstN),
    .ieWe(ieWe), .ieWdata(ieWdata),
    .prioWe(prioWe), .prioWdata(prioWdata),
    .setIn(setIn), .swClr(swClr), .strobe(strobe),
    .ieRdata(ieRdata), .prioRdata(prioRdata), .flagState(flagState),
    .pendHi(pendHi), .pendLo(pendLo)
  );

  irq_poll_ctl #(.CYC_LEN(CYC_LEN)) u_ctl (
    .clk(clk), .rstN(rstN),
    .pendHi(pendHi), .pendLo(pendLo),
    .irqTake(irqTake), .retAck(retAck),
    .strobe(strobe), .irqReq(irqReq), .irqVec(irqVec), .inSvc(inSvc)
  );
endmodule

// File: tb/test_irq_poll_unit.sv
`timescale 1ns/1ps
module test_irq_poll_unit;
  localparam int CYC = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ieWe = 1'b0;
  logic [7:0] ieWdata = '0;
  logic [7:0] ieRdata;
  logic       prioWe = 1'b0;
  logic [5:0] prioWdata = '0;
  logic [5:0] prioRdata;
  logic [6:0] setIn = '0;
  logic [6:0] swClr = '0;
  logic [6:0] flagState;
  logic       irqTake = 1'b0;
  logic       retAck = 1'b0;
  logic       irqReq;
  logic [2:0] irqVec;
  logic [1:0] inSvc;

  always #5 clk = ~clk;

  irq_poll_unit #(.CYC_LEN(CYC)) i_irq_poll_unit (
    .clk(clk), .rstN(rstN),
    .ieWe(ieWe), .ieWdata(ieWdata), .ieRdata(ieRdata),
    .prioWe(prioWe), .prioWdata(prioWdata), .prioRdata(prioRdata),
    .setIn(setIn), .swClr(swClr), .flagState(flagState),
    .irqTake(irqTake), .retAck(retAck),
    .irqReq(irqReq), .irqVec(irqVec), .inSvc(inSvc)
  );

  int nChk = 0;
  int nFail = 0;
  bit running = 1'b0;

  // behavioural reference state
  int       mPhase;
  bit [5:0] mEn, mPrio;
  bit       mGlob;
  bit [6:0] mFlag;
  bit       mSeen0, mSeen1;
  bit       mReq, mLvl;
  int       mVec;
  bit [1:0] mSvc;

  always @(posedge clk or negedge rstN) begin : model
    bit [5:0] v, pend, pHi, pLo;
    bit [6:0] clr, f;
    bit [1:0] svc;
    bit poll, tk;
    if (!rstN) begin
      mPhase = 0; mEn = 0; mPrio = 0; mGlob = 0; mFlag = 0;
      mSeen0 = 0; mSeen1 = 0; mReq = 0; mLvl = 0; mVec = 0; mSvc = 0;
    end else begin
      v[0] = mFlag[0]; v[1] = mFlag[1] && mSeen0; v[2] = mFlag[2];
      v[3] = mFlag[3] && mSeen1; v[4] = mFlag[4]; v[5] = mFlag[5] || mFlag[6];
      pend = mGlob ? (v & mEn) : 6'd0;
      pHi = pend & mPrio;
      pLo = pend & ~mPrio;
      poll = (mPhase == CYC - 1);
      tk = irqTake && mReq;
      svc = mSvc;
      if (retAck) begin
        if (svc[1]) svc[1] = 0; else svc[0] = 0;
      end
      if (tk) svc[mLvl] = 1;
      clr = swClr;
      if (tk && mVec < 4) clr[mVec] = 1;
      f = (mFlag & ~clr) | setIn;
      if (poll) begin mSeen0 = f[1]; mSeen1 = f[3]; end
      else begin mSeen0 = mSeen0 && f[1]; mSeen1 = mSeen1 && f[3]; end
      if (tk) mReq = 0;
      else if (poll) begin
        mReq = 0;
        if (pHi != 0 && !mSvc[1]) begin
          mReq = 1; mLvl = 1;
          for (int i = 5; i >= 0; i--) if (pHi[i]) mVec = i;
        end else if (pLo != 0 && mSvc == 0) begin
          mReq = 1; mLvl = 0;
          for (int i = 5; i >= 0; i--) if (pLo[i]) mVec = i;
        end
      end
      mFlag = f;
      mSvc = svc;
      if (ieWe) begin mEn = ieWdata[5:0]; mGlob = ieWdata[7]; end
      if (prioWe) mPrio = prioWdata;
      mPhase = poll ? 0 : mPhase + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (running && rstN) begin
      chk("R3 enable readback", ieRdata, {mGlob, 1'b0, mEn});
      chk("R8 priority readback", prioRdata, mPrio);
      chk("R10 flag state", flagState, mFlag);
      chk("R7 request", irqReq, mReq);
      if (mReq) chk("R8 vector", irqVec, mVec);
      chk("R11 in-service", inSvc, mSvc);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic toPollDone();
    while (mPhase != CYC - 1) tick();
    tick();
  endtask
  task automatic pulseSet(input logic [6:0] m); setIn = m; tick(); setIn = '0; endtask
  task automatic pulseClr(input logic [6:0] m); swClr = m; tick(); swClr = '0; endtask
  task automatic wrIe(input logic [7:0] d); ieWe = 1; ieWdata = d; tick(); ieWe = 0; endtask
  task automatic wrPrio(input logic [5:0] d); prioWe = 1; prioWdata = d; tick(); prioWe = 0; endtask
  task automatic takeIt(); irqTake = 1; tick(); irqTake = 0; endtask
  task automatic ret(); retAck = 1; tick(); retAck = 0; endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 ieRdata", ieRdata, 0);
    chk("R1 prioRdata", prioRdata, 0);
    chk("R1 flagState", flagState, 0);
    chk("R1 irqReq", irqReq, 0);
    chk("R1 inSvc", inSvc, 0);
    rstN = 1;
    running = 1;
    tick();

    // R3 unimplemented bit
    wrIe(8'hFF);
    chk("R3 bit6 reads zero", ieRdata, 8'hBF);
    wrIe(8'hBF);

    // R5 tmr0 seen one machine cycle late
    toPollDone();
    pulseSet(7'h02);
    toPollDone();
    chk("R5 tmr0 not yet polled", irqReq, 0);
    toPollDone();
    chk("R5 tmr0 polled next cycle", irqReq, 1);
    chk("R5 tmr0 vector", irqVec, 1);
    takeIt();
    chk("R10 tmr0 flag cleared", flagState, 0);
    chk("R10 low in service", inSvc, 2'b01);
    ret();
    chk("R11 return clears low", inSvc, 2'b00);

    // R6 tmr2 seen in the same cycle, R4 flags kept on take
    toPollDone();
    pulseSet(7'h20);
    toPollDone();
    chk("R6 tmr2 same-cycle request", irqReq, 1);
    chk("R6 tmr2 vector", irqVec, 5);
    takeIt();
    chk("R4 tmr2 flag kept", flagState, 7'h20);
    ret();
    pulseClr(7'h20);
    chk("R4 software clear", flagState, 0);
    toPollDone();
    chk("R4 nothing pending", irqReq, 0);

    // R8 ordering and levels
    pulseSet(7'h14);
    toPollDone();
    chk("R8 ext1 before serial", irqVec, 2);
    wrPrio(6'h10);
    toPollDone();
    chk("R8 high serial first", irqVec, 4);
    takeIt();
    chk("R10 high in service", inSvc, 2'b10);
    chk("R10 serial flag kept", flagState, 7'h14);
    toPollDone();
    chk("R9 low blocked under high", irqReq, 0);
    ret();
    chk("R11 return clears high", inSvc, 2'b00);
    pulseClr(7'h10);
    toPollDone();
    chk("R8 ext1 low now served", irqVec, 2);
    takeIt();
    chk("R10 ext1 cleared", flagState, 0);
    pulseSet(7'h01);
    toPollDone();
    chk("R9 low cannot pre-empt low", irqReq, 0);
    pulseSet(7'h10);
    toPollDone();
    chk("R9 high pre-empts low req", irqReq, 1);
    chk("R9 high pre-empts low vec", irqVec, 4);
    takeIt();
    chk("R9 nested levels", inSvc, 2'b11);
    pulseClr(7'h10);
    ret();
    chk("R11 first return clears high", inSvc, 2'b01);
    ret();
    chk("R11 second return clears low", inSvc, 2'b00);
    toPollDone();
    chk("R8 ext0 served after unwind", irqVec, 0);
    takeIt();
    ret();

    // R2 global enable
    wrIe(8'h3F);
    pulseSet(7'h01);
    toPollDone();
    toPollDone();
    chk("R2 global off blocks", irqReq, 0);
    wrIe(8'h81);
    toPollDone();
    chk("R2 enabled ext0 req", irqReq, 1);
    chk("R2 enabled ext0 vec", irqVec, 0);
    takeIt();
    ret();

    // R12 set wins over clear
    setIn = 7'h10; swClr = 7'h10; tick(); setIn = '0; swClr = '0;
    chk("R12 set wins", flagState[4], 1);
    pulseClr(7'h10);

    // random traffic on arbitrary phases
    wrIe(8'hBF);
    for (int n = 0; n < 5000; n++) begin
      setIn   = ($urandom % 6 == 0) ? 7'($urandom) : 7'd0;
      swClr   = ($urandom % 10 == 0) ? 7'($urandom) : 7'd0;
      irqTake = irqReq && ($urandom % 3 == 0);
      retAck  = ($urandom % 15 == 0);
      ieWe    = ($urandom % 150 == 0);
      ieWdata = 8'($urandom) | (($urandom % 4 != 0) ? 8'h80 : 8'h00);
      prioWe  = ($urandom % 120 == 0);
      prioWdata = 6'($urandom);
      tick();
    end
    setIn = '0; swClr = '0; irqTake = 0; retAck = 0; ieWe = 0; prioWe = 0;
    repeat (4) tick();
    finishRun();
  end
endmodule